// File: doc/BRIEF.md
# Intersection Pictogram Matrix Scanner

This block paints a crossroads symbol on a square LED matrix of 16 rows and 16 columns. It scans one row at a time. Each scan tick lights the next row, driving a one-hot row select together with the 16 column bits for that row. The picture is built as the rows are scanned. A fixed outline of two crossing roads is always present. An arrow showing the permitted direction of passage is ORed on top of it.

The signal controller supplies the direction that currently has green and a priority-override flag. With east-west green, a horizontal double-headed arrow is drawn through the crossing. With north-south green, a vertical one is drawn. While an emergency vehicle holds the override, or while no direction is green, the arrow is dropped and only the outline remains, which shows that nobody may pass. The arrow choice is sampled only when a new frame starts, so that a single frame never mixes two pictures.

Top module: `xing_matrix_drv`

## Requirements
- R1: While reset is low, and afterwards until the first scan tick, `row_sel` and `col_data` are all zero. The first scan tick after reset shows row 0.
- R2: Each later scan tick shows the next row (row r+1, and row 0 after row 15). Once the first tick has arrived, `row_sel` has exactly one bit set, and bit r marks row r.
- R3: The outline is fixed. Rows 5 and 10 light columns 0..5 and 10..15. Rows 0..4 and 11..15 light columns 5 and 10. Rows 6..9 carry no outline pixels. Bit c of `col_data` is column c.
- R4: The east-west arrow lights columns 2..13 of row 7, plus columns 3 and 12 of rows 6 and 8.
- R5: The north-south arrow lights column 7 in rows 2..13, plus columns 6 and 8 in rows 3 and 12.
- R6: `col_data` is the outline row ORed with the arrow row. `green_dir` 2'b01 selects east-west and 2'b10 selects north-south. Codes 2'b00 and 2'b11 select no arrow. `prio_hold` high suppresses the arrow whatever `green_dir` is.
- R7: `green_dir` and `prio_hold` are sampled only on the tick that shows row 0. Changes on those inputs during rows 1..15 have no effect until the next frame.
- R8: The outputs change only in the clock cycle after a cycle with `scan_tick` high. Without a tick they hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| scan_tick | input | 1 | One-cycle pulse that advances the scan by one row |
| green_dir | input | 2 | Green direction: 01 east-west, 10 north-south, 00/11 none |
| prio_hold | input | 1 | Priority-vehicle override; high removes the arrow |
| row_sel | output | 16 | One-hot row select, bit r for row r |
| col_data | output | 16 | Column pixels of the selected row, bit c for column c |

## Verification
The assertions assume that `scan_tick` is a clean synchronous pulse. They also assume that `green_dir` and `prio_hold` are synchronous levels that may change on any cycle, including mid-frame and between ticks. The bench drives every input at the falling clock edge. It keeps ticks one or more cycles apart, and it changes the direction and override inputs both at frame boundaries and in the middle of frames. This covers the frame-latching rule without ever breaking the single-cycle nature of the tick.

// File: rtl/xing_pkg.sv
// Package xing_pkg
// Shared types and pixel geometry for the intersection pictogram scanner.
// Assumes a square matrix of at least 16 rows. The geometry scales about the centre.
package xing_pkg;

    // Arrow overlay chosen for a frame
    typedef enum logic [1:0] {
        PAT_NONE = 2'd0,
        PAT_EW   = 2'd1,
        PAT_NS   = 2'd2
    } pat_e;

    localparam logic [1:0] GREEN_EW = 2'b01;
    localparam logic [1:0] GREEN_NS = 2'b10;

    // Outline pixel: edges of two crossing roads, open in the middle
    function automatic logic outline_px(input int dim, input int r, input int c);
        int lo;
        int hi;
        logic horiz;
        logic vert;
        lo = dim / 2 - 3;
        hi = dim / 2 + 2;
        horiz = ((r == lo) || (r == hi)) && ((c <= lo) || (c >= hi));
        vert  = ((c == lo) || (c == hi)) && ((r <= lo) || (r >= hi));
        return horiz || vert;
    endfunction

    // Horizontal double-headed arrow pixel
    function automatic logic ew_px(input int dim, input int r, input int c);
        int mid;
        mid = dim / 2 - 1;
        if (r == mid)
            return (c >= 2) && (c <= dim - 3);
        else if ((r == mid - 1) || (r == mid + 1))
            return (c == 3) || (c == dim - 4);
        else
            return 1'b0;
    endfunction

    // Vertical arrow: the horizontal one transposed
    function automatic logic ns_px(input int dim, input int r, input int c);
        return ew_px(dim, c, r);
    endfunction

    // Map controller state to an overlay; the override wins
    function automatic pat_e decode_pat(input logic [1:0] green, input logic prio);
        if (prio)
            return PAT_NONE;
        else if (green == GREEN_EW)
            return PAT_EW;
        else if (green == GREEN_NS)
            return PAT_NS;
        else
            return PAT_NONE;
    endfunction

endpackage

// File: rtl/xing_row_scan.sv
// Module xing_row_scan
// Keeps the row index of the scan. A tick moves to the row that will be shown next.
// The first tick after reset shows row 0 and sets the running flag.
// Assumes scan_tick is a synchronous single-cycle pulse.
module xing_row_scan #(
    parameter int DIM = 16,
    parameter int RW  = $clog2(DIM)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scan_tick,
    output logic [RW-1:0] next_row,
    output logic          frame_load,
    output logic          started
);
    localparam logic [RW-1:0] LAST_ROW = RW'(DIM - 1);

    logic [RW-1:0] row_q;

    // Next row to display: row 0 before the first tick and after the last row
    always_comb begin
        if (!started || (row_q == LAST_ROW))
            next_row = '0;
        else
            next_row = row_q + 1'b1;
    end

    // A tick that shows row 0 opens a new frame
    assign frame_load = scan_tick && (next_row == '0);

    // Register the displayed row and the running flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q   <= '0;
            started <= 1'b0;
        end else if (scan_tick) begin
            row_q   <= next_row;
            started <= 1'b1;
        end
    end

    AST_ROW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_tick && started && row_q == LAST_ROW) |=> (row_q == '0)); // R2

    AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_tick && started && row_q != LAST_ROW) |=> (row_q == $past(row_q) + 1'b1)); // R2

    AST_FIRST_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_tick && !started) |=> (row_q == '0 && started)); // R1

endmodule

// File: rtl/xing_pat_sel.sv
// Module xing_pat_sel
// Holds the overlay chosen for the current frame. The inputs are sampled only on the frame-start load.
// During the load cycle the fresh choice passes straight through, so row 0 already uses it.
// Assumes green_dir and prio_hold are synchronous to clk.
module xing_pat_sel
    import xing_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [1:0] green_dir,
    input  logic       prio_hold,
    output pat_e       pat_eff
);
    pat_e pat_q;
    pat_e pat_new;

    // Decode the controller state into an overlay choice
    assign pat_new = decode_pat(green_dir, prio_hold);

    // The row being loaded now uses the fresh choice only at frame start
    assign pat_eff = load ? pat_new : pat_q;

    // Latch the choice for the remaining rows of the frame
    always_ff @(posedge clk) begin
        if (!rst_n)
            pat_q <= PAT_NONE;
        else if (load)
            pat_q <= pat_new;
    end

    AST_PRIO_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
        (load && prio_hold) |=> (pat_q == PAT_NONE)); // R6

    AST_EW_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !prio_hold && green_dir == GREEN_EW) |=> (pat_q == PAT_EW)); // R6

    AST_MIDFRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !$stable(green_dir)) |=> $stable(pat_q)); // R7

endmodule

// File: rtl/xing_bitmap_rom.sv
// Module xing_bitmap_rom
// Combinational row lookup of the outline and of both arrow overlays.
// Every pixel is computed from the geometry functions, so no table is stored.
// Assumes row_i < DIM.
module xing_bitmap_rom
    import xing_pkg::*;
#(
    parameter int DIM = 16,
    parameter int RW  = $clog2(DIM)
) (
    input  logic [RW-1:0]  row_i,
    output logic [DIM-1:0] base_o,
    output logic [DIM-1:0] ew_o,
    output logic [DIM-1:0] ns_o
);
    // One pixel generator per column for each image layer
    for (genvar c = 0; c < DIM; c++) begin : g_col
        assign base_o[c] = outline_px(DIM, int'(row_i), c);
        assign ew_o[c]   = ew_px(DIM, int'(row_i), c);
        assign ns_o[c]   = ns_px(DIM, int'(row_i), c);
    end

endmodule

// File: rtl/xing_matrix_drv.sv
// Module xing_matrix_drv
// Row-scanning driver for the intersection pictogram. On each scan tick it registers
// a one-hot row select and the column pixels: the outline ORed with the arrow
// chosen for the frame. Outputs are blank from reset until the first tick.
// Assumes scan_tick is a single-cycle pulse synchronous to clk.
module xing_matrix_drv
    import xing_pkg::*;
#(
    parameter int DIM = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           scan_tick,
    input  logic [1:0]     green_dir,
    input  logic           prio_hold,
    output logic [DIM-1:0] row_sel,
    output logic [DIM-1:0] col_data
);
    localparam int RW = $clog2(DIM);
    localparam logic [DIM-1:0] ONE_HOT0 = {{(DIM-1){1'b0}}, 1'b1};

    logic [RW-1:0]  next_row;
    logic           frame_load;
    logic           started;
    pat_e           pat_eff;
    logic [DIM-1:0] base_row;
    logic [DIM-1:0] ew_row;
    logic [DIM-1:0] ns_row;
    logic [DIM-1:0] arrow_row;

    xing_row_scan #(.DIM(DIM), .RW(RW)) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .scan_tick  (scan_tick),
        .next_row   (next_row),
        .frame_load (frame_load),
        .started    (started)
    );

    xing_pat_sel u_pat (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (frame_load),
        .green_dir (green_dir),
        .prio_hold (prio_hold),
        .pat_eff   (pat_eff)
    );

    xing_bitmap_rom #(.DIM(DIM), .RW(RW)) u_rom (
        .row_i  (next_row),
        .base_o (base_row),
        .ew_o   (ew_row),
        .ns_o   (ns_row)
    );

    // Pick the arrow layer for the frame, or none
    always_comb begin
        case (pat_eff)
            PAT_EW:  arrow_row = ew_row;
            PAT_NS:  arrow_row = ns_row;
            default: arrow_row = '0;
        endcase
    end

    // Register the row select and the composed column word on each tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_sel  <= '0;
            col_data <= '0;
        end else if (scan_tick) begin
            row_sel  <= ONE_HOT0 << next_row;
            col_data <= base_row | arrow_row;
        end
    end

    AST_BLANK_UNTIL_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !started |-> (row_sel == '0 && col_data == '0)); // R1

    AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        started |-> $onehot(row_sel)); // R2

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_tick |=> ($stable(row_sel) && $stable(col_data))); // R8

    AST_OUTLINE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        scan_tick |=> ((col_data & $past(base_row)) == $past(base_row))); // R3

endmodule

// File: tb/xing_matrix_drv_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected rows, the monitor pops and compares them.
module xing_matrix_drv_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scan_tick = 1'b0;
    logic [1:0]  green_dir = 2'b00;
    logic        prio_hold = 1'b0;
    logic [15:0] row_sel;
    logic [15:0] col_data;

    typedef struct {
        logic [15:0] rs;
        logic [15:0] col;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    int          n_chk = 0;
    int          n_fail = 0;
    logic        tick_seen = 1'b0;
    logic [15:0] img [3][16];   // 0 outline only, 1 with EW arrow, 2 with NS arrow
    int          brow = -1;
    int          bpat = 0;
    logic [15:0] last_rs = '0;
    logic [15:0] last_col = '0;

    always #4 clk = ~clk;   // 125 MHz

    xing_matrix_drv u_xing_matrix_drv (
        .clk       (clk),
        .rst_n     (rst_n),
        .scan_tick (scan_tick),
        .green_dir (green_dir),
        .prio_hold (prio_hold),
        .row_sel   (row_sel),
        .col_data  (col_data)
    );

    // Draw the expected images from the stated geometry (R3, R4, R5)
    initial begin
        for (int r = 0; r < 16; r++) img[0][r] = '0;
        for (int i = 0; i < 16; i++) begin
            if (i < 6 || i > 9) begin
                img[0][5][i]  = 1'b1;
                img[0][10][i] = 1'b1;
                img[0][i][5]  = 1'b1;
                img[0][i][10] = 1'b1;
            end
        end
        for (int r = 0; r < 16; r++) begin
            img[1][r] = img[0][r];
            img[2][r] = img[0][r];
        end
        for (int i = 2; i <= 13; i++) begin
            img[1][7][i] = 1'b1;
            img[2][i][7] = 1'b1;
        end
        img[1][6][3] = 1'b1; img[1][6][12] = 1'b1;
        img[1][8][3] = 1'b1; img[1][8][12] = 1'b1;
        img[2][3][6] = 1'b1; img[2][3][8] = 1'b1;
        img[2][12][6] = 1'b1; img[2][12][8] = 1'b1;
    end

    task automatic check(input string tag, input logic [15:0] rs, input logic [15:0] ers,
                         input logic [15:0] col, input logic [15:0] ecol);
        n_chk++;
        if (rs !== ers || col !== ecol) begin
            n_fail++;
            $display("FAIL %s: row_sel=%h exp %h col_data=%h exp %h", tag, rs, ers, col, ecol);
        end
    endtask

    // Driver: one scan tick with its expected result pushed to the scoreboard
    task automatic tick(input string tag, input int gap);
        exp_t e;
        int   nxt;
        @(negedge clk);
        nxt = (brow < 0 || brow == 15) ? 0 : brow + 1;
        if (nxt == 0) begin
            if (prio_hold) bpat = 0;
            else if (green_dir == 2'b01) bpat = 1;
            else if (green_dir == 2'b10) bpat = 2;
            else bpat = 0;
        end
        brow  = nxt;
        e.rs  = 16'h0001 << nxt;
        e.col = img[bpat][nxt];
        e.tag = tag;
        last_rs  = e.rs;
        last_col = e.col;
        sb_q.push_back(e);
        scan_tick = 1'b1;
        @(negedge clk);
        scan_tick = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 reset blank", row_sel, '0, col_data, '0);
        rst_n = 1'b1;
        brow = -1;
        repeat (3) @(negedge clk);
        check("R1 idle after reset", row_sel, '0, col_data, '0);
    endtask

    // Record which edges carried a tick
    always @(posedge clk) tick_seen <= scan_tick;

    // Monitor: compare the design output after each tick edge
    initial begin
        forever begin
            @(negedge clk);
            if (tick_seen) begin
                if (sb_q.size() == 0) begin
                    n_chk++; n_fail++;
                    $display("FAIL R2: output after tick with no expected item");
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(e.tag, row_sel, e.rs, col_data, e.col);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Stimulus
    initial begin
        repeat (3) @(negedge clk);
        check("R1 during reset", row_sel, '0, col_data, '0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 before first tick", row_sel, '0, col_data, '0);

        // Frame of east-west green; switch to NS mid-frame (R4, R7)
        green_dir = 2'b01;
        for (int i = 0; i < 16; i++) begin
            if (i == 6) green_dir = 2'b10;
            tick("R4 R7 east-west frame", i % 3);
        end

        // North-south frame; override raised mid-frame has no effect yet (R5, R7)
        for (int i = 0; i < 16; i++) begin
            if (i == 9) prio_hold = 1'b1;
            tick("R5 R7 north-south frame", 0);
        end

        // Override frame: arrow gone despite NS green (R6)
        for (int i = 0; i < 16; i++) tick("R6 override blanks arrow", 1);

        // Hold without ticks (R8)
        repeat (6) @(negedge clk);
        check("R8 hold without tick", row_sel, last_rs, col_data, last_col);

        // No-green codes (R6)
        prio_hold = 1'b0;
        green_dir = 2'b11;
        for (int i = 0; i < 16; i++) tick("R6 code 11 no arrow", 0);
        green_dir = 2'b00;
        for (int i = 0; i < 16; i++) tick("R6 code 00 no arrow", 0);

        // Override wins over EW green (R6)
        green_dir = 2'b01;
        prio_hold = 1'b1;
        for (int i = 0; i < 16; i++) tick("R6 override over east-west", 0);

        // Release: EW arrow back; wrap checked again (R2, R4)
        prio_hold = 1'b0;
        for (int i = 0; i < 20; i++) tick("R2 R4 wrap and release", 2);

        // Reset mid-frame, then restart at row 0 (R1)
        @(negedge clk);
        do_reset();
        green_dir = 2'b10;
        for (int i = 0; i < 16; i++) tick("R1 R5 restart after reset", 0);

        repeat (3) @(negedge clk);
        if (sb_q.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL R2: %0d expected rows never produced (exp 0)", sb_q.size());
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule